// File: doc/BRIEF.md
# Deferred Exception Token Tracker

This block keeps a one-bit deferral token beside each general register, so that every register behaves as a 65-bit value whose extra bit marks "no valid data, a fault is pending". Only a speculative load that meets a fault may create a token. The token then spreads to any register written by an instruction that consumed a tokened value.

A non-speculative consumer of a token does not defer it: it raises an unrecoverable exception. An explicit speculation check on a register reports whether a branch to recovery code is needed. A direct save/restore path lets context-switch code read and write tokens without triggering anything.

Each instruction that completes presents one write-back event. The tracker updates its token array on the clock edge, and reports exceptions and check outcomes one cycle after the event. The data path and the recovery code live elsewhere.

Top module: `nat_tag_tracker`

## Requirements
- R1: After reset every token is clear, and `exc_nat`, `exc_fault` and `chk_branch` are low.
- R2: Register 0 always reads as untokened through the save port. Write-backs and restores aimed at register 0 have no effect.
- R3: A speculative load (`wb_spec`=1, `wb_load`=1) that faults, with a destination enabled and non-zero, sets the destination token and raises no exception.
- R4: A speculative instruction whose enabled source carries a token writes a tokened destination and raises no exception.
- R5: A non-speculative instruction whose enabled source carries a token drives `exc_nat` high in the next cycle. The destination token is left unchanged. This takes priority over `exc_fault`.
- R6: A non-speculative faulting load with untokened sources drives `exc_fault` high in the next cycle and leaves the destination token unchanged.
- R7: A write-back that neither faults nor reads a token clears the destination token, whether or not it is speculative.
- R8: A source register whose enable is low is not consulted. `wb_fault` has no effect when `wb_load` is low.
- R9: When `chk_valid` is high, `chk_branch` in the next cycle equals the token of `chk_reg` as it stood before that edge. With `chk_valid` low, `chk_branch` is low.
- R10: `sv_tag` shows the token of `sv_reg` combinationally. A restore (`rs_we`) writes `rs_tag` into `rs_reg` with no exception. When a write-back hits the same register in the same cycle, the write-back wins.
- R11: An event with `wb_dst_en` low changes no token, although it can still raise an exception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wb_valid | input | 1 | Write-back event present |
| wb_dst_en | input | 1 | Event writes a destination register |
| wb_dst | input | AW | Destination register index |
| wb_a_en | input | 1 | First source is read |
| wb_a | input | AW | First source index |
| wb_b_en | input | 1 | Second source is read |
| wb_b | input | AW | Second source index |
| wb_spec | input | 1 | Instruction is speculative |
| wb_load | input | 1 | Instruction is a load |
| wb_fault | input | 1 | Load met a fault |
| chk_valid | input | 1 | Speculation check requested |
| chk_reg | input | AW | Register to check |
| chk_branch | output | 1 | Branch to recovery, one cycle after the check |
| exc_nat | output | 1 | Unrecoverable use of a token by a non-speculative instruction |
| exc_fault | output | 1 | Immediate fault of a non-speculative load |
| sv_reg | input | AW | Save-port register index |
| sv_tag | output | 1 | Save-port token read |
| rs_we | input | 1 | Restore-port write enable |
| rs_reg | input | AW | Restore-port register index |
| rs_tag | input | 1 | Restore-port token value |

## Verification
A wrong token shows up only when something reads it. A corrupted bit can therefore sit silently until a later check, a non-speculative consumer or a save-port read picks that register. The bench reads a random register through the save port every cycle and draws its indices from a small set, so a stale or missing token surfaces within a few cycles. Exception and check outputs are compared one cycle after each event. This catches a swapped priority or an off-by-one-cycle error at once.

// File: rtl/nat_tag_tracker.sv
module nat_tag_tracker #(
  parameter int NREGS = 128,
  localparam int AW = $clog2(NREGS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wb_valid,
  input  logic          wb_dst_en,
  input  logic [AW-1:0] wb_dst,
  input  logic          wb_a_en,
  input  logic [AW-1:0] wb_a,
  input  logic          wb_b_en,
  input  logic [AW-1:0] wb_b,
  input  logic          wb_spec,
  input  logic          wb_load,
  input  logic          wb_fault,
  input  logic          chk_valid,
  input  logic [AW-1:0] chk_reg,
  output logic          chk_branch,
  output logic          exc_nat,
  output logic          exc_fault,
  input  logic [AW-1:0] sv_reg,
  output logic          sv_tag,
  input  logic          rs_we,
  input  logic [AW-1:0] rs_reg,
  input  logic          rs_tag
);

  logic [NREGS-1:0] tags;

  wire src_hot  = (wb_a_en & tags[wb_a]) | (wb_b_en & tags[wb_b]);
  wire ld_fault = wb_load & wb_fault;
  wire dst_ok   = wb_valid & wb_dst_en & (wb_dst != '0);
  wire wr_en    = dst_ok & (wb_spec | (~src_hot & ~ld_fault));
  wire wr_val   = wb_spec & (src_hot | ld_fault);

  assign sv_tag = tags[sv_reg];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tags       <= '0;
      exc_nat    <= 1'b0;
      exc_fault  <= 1'b0;
      chk_branch <= 1'b0;
    end else begin
      if (rs_we && rs_reg != '0) tags[rs_reg] <= rs_tag;
      if (wr_en) tags[wb_dst] <= wr_val;
      exc_nat    <= wb_valid & ~wb_spec & src_hot;
      exc_fault  <= wb_valid & ~wb_spec & ~src_hot & ld_fault;
      chk_branch <= chk_valid & tags[chk_reg];
    end
  end

endmodule

module nat_tag_tracker_chk #(
  parameter int NREGS = 128,
  localparam int AW = $clog2(NREGS)
) (
  input logic          clk,
  input logic          rst_n,
  input logic [NREGS-1:0] tags,
  input logic          wb_valid,
  input logic          wb_dst_en,
  input logic [AW-1:0] wb_dst,
  input logic          wb_a_en,
  input logic [AW-1:0] wb_a,
  input logic          wb_b_en,
  input logic [AW-1:0] wb_b,
  input logic          wb_spec,
  input logic          wb_load,
  input logic          wb_fault,
  input logic          chk_valid,
  input logic [AW-1:0] chk_reg,
  input logic          chk_branch,
  input logic          exc_nat,
  input logic          exc_fault,
  input logic [AW-1:0] sv_reg,
  input logic          sv_tag,
  input logic          rs_we,
  input logic [AW-1:0] rs_reg
);

  wire hot   = (wb_a_en && tags[wb_a]) || (wb_b_en && tags[wb_b]);
  wire dstok = wb_valid && wb_dst_en && wb_dst != '0;

  p_reg0_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sv_reg == '0 |-> !sv_tag);

  p_spec_fault_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dstok && wb_spec && wb_load && wb_fault |=> tags[$past(wb_dst)]);

  p_spec_spread_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dstok && wb_spec && hot |=> tags[$past(wb_dst)] && !exc_nat);

  p_nat_raise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid && !wb_spec && hot |=> exc_nat && !exc_fault);

  p_nat_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dstok && !wb_spec && hot && !(rs_we && rs_reg == wb_dst)
    |=> tags[$past(wb_dst)] == $past(tags[wb_dst]));

  p_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(exc_nat && exc_fault));

  p_clean_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dstok && !hot && !(wb_load && wb_fault) |=> !tags[$past(wb_dst)]);

  p_chk_r9: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid |=> chk_branch == $past(tags[chk_reg]));

  p_chk_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_valid |=> !chk_branch);

endmodule

bind nat_tag_tracker nat_tag_tracker_chk #(.NREGS(NREGS)) u_chk (.*);

// File: tb/nat_tag_tracker_test.sv
module nat_tag_tracker_test;
  localparam int NREGS = 128;
  localparam int AW = $clog2(NREGS);

  logic clk = 0, rst_n = 0;
  logic wb_valid = 0, wb_dst_en = 0, wb_a_en = 0, wb_b_en = 0;
  logic wb_spec = 0, wb_load = 0, wb_fault = 0;
  logic [AW-1:0] wb_dst = 0, wb_a = 0, wb_b = 0, chk_reg = 0, sv_reg = 0, rs_reg = 0;
  logic chk_valid = 0, rs_we = 0, rs_tag = 0;
  logic chk_branch, exc_nat, exc_fault, sv_tag;

  int checks = 0, fails = 0;
  logic model [NREGS];
  logic e_nat, e_fault, e_chk;

  always #4 clk = ~clk;

  nat_tag_tracker #(.NREGS(NREGS)) uut (.*);

  initial begin
    #1_000_000;
    checks++; fails++;
    $display("FAIL watchdog: run hung");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  function automatic logic hot_src();
    return (wb_a_en && model[wb_a]) || (wb_b_en && model[wb_b]);
  endfunction

  // Drive at negedge beforehand; applies one edge and checks registered outputs.
  task automatic step(string req);
    logic h, lf, wen, wval;
    h = hot_src();
    lf = wb_load && wb_fault;
    e_nat   = wb_valid && !wb_spec && h;
    e_fault = wb_valid && !wb_spec && !h && lf;
    e_chk   = chk_valid && model[chk_reg];
    wen  = wb_valid && wb_dst_en && wb_dst != 0 && (wb_spec || (!h && !lf));
    wval = wb_spec && (h || lf);
    #1 check("R10 save read", sv_tag, model[sv_reg]);
    @(posedge clk);
    if (rs_we && rs_reg != 0) model[rs_reg] = rs_tag;
    if (wen) model[wb_dst] = wval;
    @(negedge clk);
    check({req, " exc_nat (R5)"}, exc_nat, e_nat);
    check({req, " exc_fault (R6)"}, exc_fault, e_fault);
    check({req, " chk_branch (R9)"}, chk_branch, e_chk);
  endtask

  task automatic idle();
    wb_valid = 0; chk_valid = 0; rs_we = 0;
  endtask

  task automatic wb(logic sp, logic ld, logic ft, int d, logic de,
                    int a, logic ae, int b, logic be);
    wb_valid = 1; wb_spec = sp; wb_load = ld; wb_fault = ft;
    wb_dst = AW'(d); wb_dst_en = de; wb_a = AW'(a); wb_a_en = ae;
    wb_b = AW'(b); wb_b_en = be; chk_valid = 0; rs_we = 0;
  endtask

  task automatic peek(string req, int r, logic exp);
    idle(); sv_reg = AW'(r); #1 check(req, sv_tag, exp);
  endtask

  initial begin
    for (int i = 0; i < NREGS; i++) model[i] = 0;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1;
    check("R1 exc_nat", exc_nat, 0);
    check("R1 exc_fault", exc_fault, 0);
    check("R1 chk_branch", chk_branch, 0);
    for (int i = 0; i < NREGS; i++) begin
      sv_reg = AW'(i); #1;
      if (sv_tag !== 1'b0) check("R1 token clear", sv_tag, 0);
    end
    checks++;

    // R3 speculative faulting load sets token
    wb(1, 1, 1, 5, 1, 0, 0, 0, 0); step("R3");
    peek("R3 token set", 5, 1);
    // R2 register 0 ignores writes
    wb(1, 1, 1, 0, 1, 0, 0, 0, 0); step("R2");
    peek("R2 wb to r0", 0, 0);
    idle(); rs_we = 1; rs_reg = 0; rs_tag = 1; step("R2");
    peek("R2 restore to r0", 0, 0);
    // R4 spread through speculative op
    wb(1, 0, 0, 6, 1, 3, 1, 5, 1); step("R4");
    peek("R4 spread", 6, 1);
    // R8 disabled source not consulted, fault without load ignored
    wb(1, 0, 1, 7, 1, 5, 0, 2, 1); step("R8");
    peek("R8 ignored src and fault", 7, 0);
    // R5 non-speculative use: exception, dst unchanged
    wb(0, 1, 1, 6, 1, 5, 1, 0, 0); step("R5");
    peek("R5 dst kept", 6, 1);
    // R6 non-speculative faulting load
    wb(1, 1, 1, 9, 1, 0, 0, 0, 0); step("R6 prep");
    wb(0, 1, 1, 9, 1, 2, 1, 0, 0); step("R6");
    peek("R6 dst kept", 9, 1);
    // R7 clean writes clear
    wb(0, 0, 0, 9, 1, 2, 1, 3, 1); step("R7");
    peek("R7 nonspec clear", 9, 0);
    wb(1, 0, 0, 5, 1, 2, 1, 0, 0); step("R7");
    peek("R7 spec clear", 5, 0);
    // R11 no destination: no write, exception still possible
    wb(1, 1, 1, 12, 0, 0, 0, 0, 0); step("R11");
    peek("R11 no write", 12, 0);
    // R9 check sees pre-edge token
    idle(); chk_valid = 1; chk_reg = 6; step("R9");
    // R10 restore and same-cycle priority
    idle(); rs_we = 1; rs_reg = 20; rs_tag = 1; step("R10");
    peek("R10 restore", 20, 1);
    wb(0, 0, 0, 20, 1, 0, 0, 0, 0); rs_we = 1; rs_reg = 20; rs_tag = 1; step("R10 priority");
    peek("R10 wb wins", 20, 0);

    for (int n = 0; n < 3000; n++) begin
      wb_valid = ($urandom % 4) != 0;
      wb_spec = $urandom % 2; wb_load = $urandom % 2; wb_fault = ($urandom % 3) == 0;
      wb_dst_en = ($urandom % 8) != 0; wb_dst = AW'($urandom % 8);
      wb_a_en = $urandom % 2; wb_a = AW'($urandom % 8);
      wb_b_en = $urandom % 2; wb_b = AW'($urandom % 8);
      chk_valid = $urandom % 2; chk_reg = AW'($urandom % 8);
      rs_we = ($urandom % 6) == 0; rs_reg = AW'($urandom % 8); rs_tag = $urandom % 2;
      sv_reg = AW'($urandom % 8);
      step("random");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule